// File: doc/BRIEF.md
# Command Queue Scan Controller

This block governs the scanning of a queue of converter command words. Commands arrive one at a time over a valid/ready handshake. The controller accepts them only while its queue status is TRIGGERED. For each accepted command it decodes five control bits:

- end-of-queue
- pause
- internal/external buffer select
- buffer number
- read/write

It routes the command to one of four message buffers: internal 0, internal 1, external 0 or external 1. It keeps a running transfer counter and raises sticky flags when a queue ends or a sub-queue pauses.

The queue status moves between IDLE, WAITING FOR TRIGGER and TRIGGERED.

- An arm pulse starts a scan.
- A trigger lets commands flow.
- A pause bit splits one queue into sub-queues, each waiting for a fresh trigger.
- End-of-queue finishes the scan. In single-scan mode the status goes back to IDLE. In continuous modes it goes back to waiting for the next trigger.

When a command carries both end-of-queue and pause, both flags are raised, but the status behaves as for end-of-queue alone.

Top module: `cmdq_scan_ctrl`

## Requirements
- R1: For an accepted command, `xferBuf` is {bit 5, bit 6} and `xferRead` is bit 7 of `cmdWord`. Bit 5 is 1 for an external buffer, bit 6 is the buffer number and bit 7 is 1 for a read. Bits 2 to 4 have no effect on any output.
- R2: `cmdReady` is high only while `status` is TRIGGERED (2). `xferValid` is high exactly when `cmdValid` and `cmdReady` are both high. A command offered in any other state causes no transfer and no counter change.
- R3: The `status` encoding is 0 for IDLE, 1 for WAITING, 2 for TRIGGERED. An `arm` pulse in IDLE with `mode` not 0 moves the status to WAITING on the next clock. `mode` 0 (off) forces IDLE.
- R4: `mode` 1 is single-scan edge, 2 is continuous-scan edge and 3 is continuous-scan level. In the edge modes a rising edge of `trigger` moves WAITING to TRIGGERED, and a trigger held high does not re-trigger. In level mode a high `trigger` does this.
- R5: Each accepted command without end-of-queue (bit 0) increments `xferCount` by one. An accepted command with end-of-queue returns it to 0.
- R6: An accepted end-of-queue command sets `eoqFlag`. It then returns the status to IDLE in mode 1, and to WAITING in modes 2 and 3.
- R7: An accepted pause command (bit 1) sets `pauseFlag`. In modes 1 and 2 it moves the status to WAITING. In mode 3 the status stays TRIGGERED.
- R8: A command with both end-of-queue and pause set raises both flags, and the status changes as for end-of-queue alone.
- R9: Both flags stay set until cleared by writing one to `flagClr`, where bit 0 clears `eoqFlag` and bit 1 clears `pauseFlag`. If a set and a clear of the same flag occur in the same cycle, the set wins.
- R10: Synchronous reset clears `xferCount` and both flags and forces the status to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Scan mode: 0 off, 1 single edge, 2 continuous edge, 3 continuous level |
| arm | input | 1 | Starts a scan from IDLE |
| trigger | input | 1 | Trigger input |
| cmdValid | input | 1 | Command word offered |
| cmdReady | output | 1 | Command accepted this cycle when valid |
| cmdWord | input | CMD_W | Command word |
| flagClr | input | 2 | Write-one-to-clear for the flags (bit 0 end-of-queue, bit 1 pause) |
| eoqFlag | output | 1 | Sticky end-of-queue flag |
| pauseFlag | output | 1 | Sticky pause flag |
| xferCount | output | CNT_W | Transfer counter |
| status | output | 2 | Queue status |
| xferValid | output | 1 | A command is transferred this cycle |
| xferBuf | output | 2 | Destination {external, number} |
| xferRead | output | 1 | Transferred command is a read |

## Verification
The hardest situation to reach is a pause inside a queue in edge mode while the trigger is still held high. Leaving WAITING then requires the trigger to fall and rise again. The stimulus pauses with the trigger high and checks that the status stays WAITING over several cycles. It then drops and re-raises the trigger. A combined end-of-queue-plus-pause command is sent in single-scan mode, where the outcome (IDLE) differs from a plain pause (WAITING). A flag clear is issued in the same cycle as a new setting command.

// File: rtl/cmdq_scan_pkg.sv
package cmdq_scan_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_TRIG = 2'd2} scanState_t;
  typedef enum logic [1:0] {MD_OFF = 2'd0, MD_SINGLE_EDGE = 2'd1,
                            MD_CONT_EDGE = 2'd2, MD_CONT_LEVEL = 2'd3} scanMode_t;
  typedef struct packed {
    logic accept;
    logic endQ;
    logic pauseHit;
  } scanStrobe_t;
  localparam int EOQ_POS   = 0;
  localparam int PAUSE_POS = 1;
  localparam int EXT_POS   = 5;
  localparam int BNUM_POS  = 6;
  localparam int READ_POS  = 7;
endpackage

// File: rtl/cmdq_scan_ctl.sv
module cmdq_scan_ctl
  import cmdq_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  mode,
  input  logic        arm,
  input  logic        trigger,
  input  logic        cmdValid,
  input  logic        cmdEoq,
  input  logic        cmdPause,
  output logic        cmdReady,
  output logic [1:0]  status,
  output scanStrobe_t strobe
);
  scanState_t state, nxt;
  scanMode_t  md;
  logic trigPrev, startHit, edgeMode, accept;

  assign md       = scanMode_t'(mode);
  assign edgeMode = (md == MD_SINGLE_EDGE) || (md == MD_CONT_EDGE);
  assign startHit = (md == MD_CONT_LEVEL) ? trigger : (trigger & ~trigPrev);
  assign cmdReady = (state == ST_TRIG);
  assign accept   = cmdValid & cmdReady;
  assign status   = state;

  assign strobe.accept   = accept;
  assign strobe.endQ     = accept & cmdEoq;
  assign strobe.pauseHit = accept & cmdPause;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (arm) nxt = ST_WAIT;
      ST_WAIT: if (startHit) nxt = ST_TRIG;
      ST_TRIG: if (accept) begin
        if (cmdEoq)                nxt = (md == MD_SINGLE_EDGE) ? ST_IDLE : ST_WAIT;
        else if (cmdPause && edgeMode) nxt = ST_WAIT;
      end
      default: nxt = ST_IDLE;
    endcase
    if (md == MD_OFF) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      trigPrev <= 1'b0;
    end else begin
      state    <= nxt;
      trigPrev <= trigger;
    end
  end

  // R6
  eoq_single_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && cmdEoq && md == MD_SINGLE_EDGE) |=> (state == ST_IDLE));
  // R8
  eoq_cont_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && cmdEoq && md != MD_SINGLE_EDGE && md != MD_OFF) |=> (state == ST_WAIT));
  // R7
  pause_edge_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && cmdPause && !cmdEoq && edgeMode) |=> (state == ST_WAIT));
  // R7
  pause_level_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !cmdEoq && md == MD_CONT_LEVEL) |=> (state == ST_TRIG));
  // R4
  no_trig_without_input_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !trigger) |=> (state != ST_TRIG));
  // R3
  off_forces_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (md == MD_OFF) |=> (state == ST_IDLE));
endmodule

// File: rtl/cmdq_scan_dp.sv
module cmdq_scan_dp
  import cmdq_scan_pkg::*;
#(
  parameter int CMD_W = 32,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  scanStrobe_t      strobe,
  input  logic [CMD_W-1:0] cmdWord,
  input  logic [1:0]       flagClr,
  output logic             eoqFlag,
  output logic             pauseFlag,
  output logic [CNT_W-1:0] xferCount,
  output logic             xferValid,
  output logic [1:0]       xferBuf,
  output logic             xferRead
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  assign xferValid = strobe.accept;
  assign xferBuf   = {cmdWord[EXT_POS], cmdWord[BNUM_POS]};
  assign xferRead  = cmdWord[READ_POS];

  always_ff @(posedge clk) begin
    if (rst) begin
      xferCount <= '0;
      eoqFlag   <= 1'b0;
      pauseFlag <= 1'b0;
    end else begin
      if (strobe.endQ)        xferCount <= '0;
      else if (strobe.accept) xferCount <= xferCount + CNT_ONE;
      if (strobe.endQ)        eoqFlag <= 1'b1;
      else if (flagClr[0])    eoqFlag <= 1'b0;
      if (strobe.pauseHit)    pauseFlag <= 1'b1;
      else if (flagClr[1])    pauseFlag <= 1'b0;
    end
  end

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.accept && !strobe.endQ) |=> (xferCount == $past(xferCount) + CNT_ONE));
  // R5
  count_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.endQ |=> (xferCount == '0));
  // R9
  eoq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (eoqFlag && !flagClr[0]) |=> eoqFlag);
  // R9
  pause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pauseFlag && !flagClr[1]) |=> pauseFlag);
  // R8
  both_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.endQ && strobe.pauseHit) |=> (eoqFlag && pauseFlag));
endmodule

// File: rtl/cmdq_scan_ctrl.sv
module cmdq_scan_ctrl
  import cmdq_scan_pkg::*;
#(
  parameter int CMD_W = 32,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             arm,
  input  logic             trigger,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [CMD_W-1:0] cmdWord,
  input  logic [1:0]       flagClr,
  output logic             eoqFlag,
  output logic             pauseFlag,
  output logic [CNT_W-1:0] xferCount,
  output logic [1:0]       status,
  output logic             xferValid,
  output logic [1:0]       xferBuf,
  output logic             xferRead
);
  scanStrobe_t strobe;

  cmdq_scan_ctl u_ctl (
    .clk(clk), .rst(rst), .mode(mode), .arm(arm), .trigger(trigger),
    .cmdValid(cmdValid), .cmdEoq(cmdWord[EOQ_POS]), .cmdPause(cmdWord[PAUSE_POS]),
    .cmdReady(cmdReady), .status(status), .strobe(strobe)
  );

  cmdq_scan_dp #(.CMD_W(CMD_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cmdWord(cmdWord), .flagClr(flagClr),
    .eoqFlag(eoqFlag), .pauseFlag(pauseFlag), .xferCount(xferCount),
    .xferValid(xferValid), .xferBuf(xferBuf), .xferRead(xferRead)
  );

  // R2
  xfer_only_triggered_chk: assert property (@(posedge clk) disable iff (rst)
    xferValid |-> (status == 2'd2 && cmdValid));
endmodule

// File: tb/tb_cmdq_scan_ctrl.sv
module tb_cmdq_scan_ctrl;
  localparam int CMD_W = 32;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic arm = 1'b0, trigger = 1'b0, cmdValid = 1'b0;
  logic [CMD_W-1:0] cmdWord = '0;
  logic [1:0] flagClr = 2'b00;
  logic cmdReady, eoqFlag, pauseFlag, xferValid, xferRead;
  logic [CNT_W-1:0] xferCount;
  logic [1:0] status, xferBuf;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [2:0] expQ[$];

  always #2.5 clk = ~clk;

  cmdq_scan_ctrl #(.CMD_W(CMD_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .mode(mode), .arm(arm), .trigger(trigger),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWord(cmdWord), .flagClr(flagClr),
    .eoqFlag(eoqFlag), .pauseFlag(pauseFlag), .xferCount(xferCount), .status(status),
    .xferValid(xferValid), .xferBuf(xferBuf), .xferRead(xferRead)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: offers a command for one cycle; pushes the expected routing if it should be taken.
  task automatic sendCmd(logic [7:0] w, bit expectTake);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord  = {{(CMD_W-8){1'b1}}, w};
    if (expectTake) expQ.push_back({w[5], w[6], w[7]});
    @(negedge clk);
    cmdValid = 1'b0;
    cmdWord  = '0;
  endtask

  task automatic pulseArm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic setTrig(logic v);
    @(negedge clk); trigger = v;
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk); #1;
      if (!rst && xferValid) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: actual=unexpected transfer expected=none");
        end else begin
          logic [2:0] e;
          e = expQ.pop_front();
          chk("R1 buffer", int'(xferBuf), int'(e[2:1]));
          chk("R1 read", int'(xferRead), int'(e[0]));
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 status", int'(status), 0);
    chk("R10 count", int'(xferCount), 0);
    chk("R10 flags", int'({eoqFlag, pauseFlag}), 0);

    // R3 arm ignored in mode off
    pulseArm();
    chk("R3 off stays idle", int'(status), 0);

    // single-scan edge
    mode = 2'd1;
    pulseArm();
    chk("R3 armed", int'(status), 1);
    sendCmd(8'h00, 0);
    chk("R2 no xfer while waiting", int'(xferCount), 0);
    setTrig(1'b1);
    chk("R4 edge trigger", int'(status), 2);
    sendCmd(8'hDC, 1);          // read, buffer 1, reserved bits set
    chk("R5 count 1", int'(xferCount), 1);
    sendCmd(8'h20, 1);          // external 0, write
    chk("R5 count 2", int'(xferCount), 2);
    sendCmd(8'hA1, 1);          // eoq, external 0, read
    chk("R5 count cleared", int'(xferCount), 0);
    chk("R6 single eoq idle", int'(status), 0);
    chk("R6 eoq flag", int'(eoqFlag), 1);

    // pause with trigger held high (edge mode)
    pulseArm();
    chk("R4 held trigger no start", int'(status), 1);
    setTrig(1'b0);
    setTrig(1'b1);
    chk("R4 re-edge start", int'(status), 2);
    sendCmd(8'h42, 1);          // pause, buffer 1
    chk("R7 pause waits", int'(status), 1);
    chk("R7 pause flag", int'(pauseFlag), 1);
    chk("R5 count after pause", int'(xferCount), 1);
    repeat (3) @(negedge clk);
    chk("R4 held trigger no retrigger", int'(status), 1);
    setTrig(1'b0);
    setTrig(1'b1);
    chk("R4 retrigger", int'(status), 2);

    // R9 clear eoq only
    @(negedge clk); flagClr = 2'b01;
    @(negedge clk); flagClr = 2'b00;
    chk("R9 eoq cleared", int'(eoqFlag), 0);
    chk("R9 pause kept", int'(pauseFlag), 1);

    // R8 both bits in single mode -> idle
    sendCmd(8'h03, 1);
    chk("R8 status as eoq", int'(status), 0);
    chk("R8 both flags", int'({eoqFlag, pauseFlag}), 3);
    chk("R8 count", int'(xferCount), 0);

    // continuous edge: eoq returns to waiting
    mode = 2'd2;
    pulseArm();
    setTrig(1'b0);
    setTrig(1'b1);
    sendCmd(8'h01, 1);
    chk("R6 continuous eoq waits", int'(status), 1);

    // R9 set wins over clear in the same cycle
    setTrig(1'b0);
    setTrig(1'b1);
    @(negedge clk);
    cmdValid = 1'b1; cmdWord = 32'h0000_0002; flagClr = 2'b10;
    expQ.push_back(3'b000);
    @(negedge clk);
    cmdValid = 1'b0; cmdWord = '0; flagClr = 2'b00;
    chk("R9 set wins", int'(pauseFlag), 1);

    // level mode: pause ignored for status
    mode = 2'd3;
    @(negedge clk);
    @(negedge clk);
    chk("R4 level start", int'(status), 2);
    sendCmd(8'h82, 1);
    chk("R7 level pause stays", int'(status), 2);
    sendCmd(8'h01, 1);
    chk("R6 level eoq waits", int'(status), 1);
    @(negedge clk);
    chk("R4 level retrigger", int'(status), 2);

    // mode off forces idle
    mode = 2'd0;
    @(negedge clk);
    chk("R3 off forces idle", int'(status), 0);
    chk("R2 ready low idle", int'(cmdReady), 0);

    repeat (2) @(negedge clk);
    chk("R1 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule